// File: doc/BRIEF.md
# DDR SDRAM Command Decoder with Bank Tracking

This block watches the control pins of a DDR SDRAM on every rising clock edge and turns them into a single decoded command. Its inputs are chip select, the row strobe, the column strobe, write enable, the clock-enable level, the bank-address bits, the address bus (whose bit 8 carries the precharge qualifier) and the data mask. The clock-enable level from the previous edge is kept inside the block, so each decode sees both the current and the prior level.

The block tracks an idle/active state for each bank and a device mode: normal, self refresh, power down or clock suspend. Each command is checked against that state. A command that fits is accepted and updates the state. A command that does not fit is still reported, and a one-cycle illegal flag is raised. The block also latches the row address on an activate and the column address on a read or write. It runs a burst counter and derives the write-data enable and the read output enable from the data mask. Auto-precharge returns a bank to idle once its burst has run out.

All outputs are registered. The result of the command sampled on a rising edge can be seen from that edge until the next one.

Top module: `ddrcmd_decoder`

## Requirements
- R1: Every output is registered on the rising clock edge. After reset, the outputs are: command NOP (code 1), illegal flag low, all banks idle, mode normal (code 0), burst, write enable and output enable low. The previous clock-enable level resets to high. Command codes: DESEL 0, NOP 1, ACT 2, PRE 3, PREA 4, WR 5, WRA 6, RD 7, RDA 8, MRS 9, EMRS 10, BST 11, AREF 12, SREF_IN 13, SREF_OUT 14, PD_IN 15, PD_OUT 16, SUSP_IN 17, SUSP_OUT 18, HOLD 19, BAD 20. Mode codes: normal 0, self refresh 1, power down 2, suspend 3.
- R2: Clock enable is high on both edges, which applies to R3–R9 and the AREF part of R10. With chip select high the command is DESEL (0) and the strobes, bank bits and address are ignored. With chip select low and row/column/write strobes H,H,H the command is NOP (1).
- R3: Strobes L,H,H are ACT (2). It is legal only when the bank selected by ba_i is idle, and it makes that bank active. row_o captures addr_i and bank_o shows the bank.
- R4: Strobes L,H,L are a precharge. With addr_i[8] low it is PRE (3) and idles the selected bank. With addr_i[8] high it is PREA (4) and idles every bank whatever ba_i holds. Both are legal in normal mode.
- R5: Strobes H,L,L are a write: WR (5), or WRA (6) when addr_i[8] is high. Strobes H,L,H are a read: RD (7), or RDA (8). Each is legal only when the selected bank is active with no auto-precharge pending. col_o captures addr_i[7:0] and ap_o shows addr_i[8].
- R6: After an accepted WRA/RDA, the bank goes idle on the BURST_LEN-th rising edge that follows. Until then the bank stays active, and a further read or write to it is illegal.
- R7: Strobes L,L,L are a mode register command. ba_i = 0 gives MRS (9) and ba_i = 1 gives EMRS (10); both are legal only while every bank is idle. Any other ba_i gives BAD (20), which is illegal.
- R8: Strobes H,H,L are BST (11). It is legal only while at least one bank is active. It ends a read burst at once, so burst_o is low after that edge.
- R9: Strobes L,L,H give AREF (12) when clock enable stays high. When clock enable falls on that edge they give SREF_IN (13), which enters self refresh (mode 1). Both need every bank idle. A rise of clock enable with DESEL or NOP in self refresh gives SREF_OUT (14) and returns to normal.
- R10: A fall of clock enable with DESEL or NOP gives PD_IN (15) and mode 2, from idle or active banks. A rise with DESEL or NOP in power down gives PD_OUT (16) and mode 0. When clock enable is low on both edges the command is HOLD (19): it is legal and all other pins are ignored.
- R11: A power-down request made while burst_o is high gives SUSP_IN (17) and mode 3. The burst and auto-precharge counters stand still until SUSP_OUT (18), which is a clock-enable rise with DESEL or NOP. Counting then resumes where it stopped.
- R12: burst_o is high for BURST_LEN cycles after an accepted read or write. wr_en_o is high during a write burst when the data mask sampled on the same edge is low. rd_oe_o behaves the same way for a read burst. Both are low while suspended.
- R13: A command that does not fit the bank state or the mode raises illegal_o for exactly the next cycle, and it leaves the bank states and the mode unchanged. A clock-enable change with pins other than those allowed gives BAD (20). PD_OUT in normal mode is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples the pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_i | input | 1 | Clock-enable level |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | BA_W | Bank address |
| addr_i | input | ROW_W | Address bus; bit AP_BIT is the precharge qualifier |
| dm_i | input | 1 | Data mask |
| cmd_o | output | 5 | Decoded command code |
| illegal_o | output | 1 | Command did not fit the state |
| bank_o | output | BA_W | Bank of the reported command |
| ap_o | output | 1 | Qualifier bit of the reported command |
| row_o | output | ROW_W | Row address of last accepted activate |
| col_o | output | COL_W | Column of last accepted read or write |
| bank_active_o | output | 2**BA_W | Per-bank active state |
| mode_o | output | 2 | Device mode code |
| burst_o | output | 1 | Data burst in progress |
| wr_en_o | output | 1 | Write data enable |
| rd_oe_o | output | 1 | Read output enable |

## Verification
The bench builds the decoder with BURST_LEN set to 3 and keeps the default widths: four banks, a 12-bit address and an 8-bit column. The short burst keeps several cases to a handful of cycles each: expiry of auto-precharge, the illegal access while it is pending, a burst stop cutting a read, and a burst frozen by clock suspend that then resumes. The default widths cover the full bank decode and the all-bank precharge.

// File: rtl/ddrcmd_pkg.sv
// Package: command and mode codes shared by the decoder and its submodules.
// Assumes: the code values are visible at the top ports and are fixed.
package ddrcmd_pkg;

    typedef enum logic [4:0] {
        CMD_DESEL    = 5'd0,
        CMD_NOP      = 5'd1,
        CMD_ACT      = 5'd2,
        CMD_PRE      = 5'd3,
        CMD_PREA     = 5'd4,
        CMD_WR       = 5'd5,
        CMD_WRA      = 5'd6,
        CMD_RD       = 5'd7,
        CMD_RDA      = 5'd8,
        CMD_MRS      = 5'd9,
        CMD_EMRS     = 5'd10,
        CMD_BST      = 5'd11,
        CMD_AREF     = 5'd12,
        CMD_SREF_IN  = 5'd13,
        CMD_SREF_OUT = 5'd14,
        CMD_PD_IN    = 5'd15,
        CMD_PD_OUT   = 5'd16,
        CMD_SUSP_IN  = 5'd17,
        CMD_SUSP_OUT = 5'd18,
        CMD_HOLD     = 5'd19,
        CMD_BAD      = 5'd20
    } cmd_e;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_SELF   = 2'd1,
        MODE_PDOWN  = 2'd2,
        MODE_SUSP   = 2'd3
    } mode_e;

endpackage

// File: rtl/ddrcmd_pin_decode.sv
// Module: pure pin decode. It maps the control pins and the two clock-enable
// levels to a raw command and knows nothing of bank or device state.
// Assumes: every power-down entry comes out as CMD_PD_IN and every exit as
// CMD_PD_OUT; the top renames them from the mode and the burst state.
module ddrcmd_pin_decode
    import ddrcmd_pkg::*;
#(
    parameter int BA_W = 2
) (
    input  logic            cke_prev_i,
    input  logic            cke_i,
    input  logic            cs_n_i,
    input  logic            ras_n_i,
    input  logic            cas_n_i,
    input  logic            we_n_i,
    input  logic [BA_W-1:0] ba_i,
    input  logic            qual_i,
    output cmd_e            raw_o
);

    logic [2:0] strobes;
    logic       quiet;

    assign strobes = {ras_n_i, cas_n_i, we_n_i};
    assign quiet   = cs_n_i || (strobes == 3'b111);

    // Purpose: pick the raw command from the clock-enable pair and the strobes.
    always_comb begin
        raw_o = CMD_BAD;
        if (!cke_prev_i) begin
            if (!cke_i)
                raw_o = CMD_HOLD;
            else
                raw_o = quiet ? CMD_PD_OUT : CMD_BAD;
        end else if (!cke_i) begin
            if (quiet)
                raw_o = CMD_PD_IN;
            else if (strobes == 3'b001)
                raw_o = CMD_SREF_IN;
            else
                raw_o = CMD_BAD;
        end else if (cs_n_i) begin
            raw_o = CMD_DESEL;
        end else begin
            case (strobes)
                3'b111:  raw_o = CMD_NOP;
                3'b011:  raw_o = CMD_ACT;
                3'b010:  raw_o = qual_i ? CMD_PREA : CMD_PRE;
                3'b100:  raw_o = qual_i ? CMD_WRA : CMD_WR;
                3'b101:  raw_o = qual_i ? CMD_RDA : CMD_RD;
                3'b110:  raw_o = CMD_BST;
                3'b001:  raw_o = CMD_AREF;
                default: begin
                    if (ba_i == BA_W'(0))
                        raw_o = CMD_MRS;
                    else if (ba_i == BA_W'(1))
                        raw_o = CMD_EMRS;
                    else
                        raw_o = CMD_BAD;
                end
            endcase
        end
    end

endmodule

// File: rtl/ddrcmd_bank_track.sv
// Module: per-bank idle/active state with an auto-precharge countdown in
// each bank.
// Assumes: the strobes arrive already qualified as legal; freeze_i stops the
// countdowns while the clock is not running internally.
module ddrcmd_bank_track #(
    parameter int BA_W      = 2,
    parameter int BURST_LEN = 4,
    localparam int NBANK    = 1 << BA_W,
    localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze_i,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic             prea_i,
    input  logic             ap_start_i,
    input  logic [BA_W-1:0]  bank_i,
    output logic [NBANK-1:0] active_o,
    output logic [NBANK-1:0] open_o
);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic             act_q;
        logic [CNT_W-1:0] ap_cnt_q;
        logic             sel;

        assign sel = (bank_i == BA_W'(g));

        // Purpose: open, close and time out this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_q    <= 1'b0;
                ap_cnt_q <= '0;
            end else if (prea_i || (pre_i && sel)) begin
                act_q    <= 1'b0;
                ap_cnt_q <= '0;
            end else if (act_i && sel) begin
                act_q    <= 1'b1;
            end else if (ap_start_i && sel) begin
                ap_cnt_q <= CNT_W'(BURST_LEN);
            end else if (ap_cnt_q != '0 && !freeze_i) begin
                ap_cnt_q <= ap_cnt_q - 1'b1;
                if (ap_cnt_q == CNT_W'(1))
                    act_q <= 1'b0;
            end
        end

        assign active_o[g] = act_q;
        assign open_o[g]   = act_q && (ap_cnt_q == '0);

        AST_AP_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
            (ap_cnt_q != '0) |-> act_q);  // R6
        AST_AP_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            ap_cnt_q <= CNT_W'(BURST_LEN));  // R6
        AST_AP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            (freeze_i && !prea_i && !pre_i) |=> $stable(ap_cnt_q));  // R11
    end

endmodule

// File: rtl/ddrcmd_burst_ctl.sv
// Module: data burst counter plus the write-data and read-output enables
// derived from the data mask.
// Assumes: start_i and stop_i are already qualified as legal; run_i is low
// while the device is not in normal mode.
module ddrcmd_burst_ctl #(
    parameter int BURST_LEN = 4,
    localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic freeze_i,
    input  logic start_i,
    input  logic is_wr_i,
    input  logic stop_i,
    input  logic dm_i,
    input  logic run_i,
    output logic busy_o,
    output logic wr_en_o,
    output logic rd_oe_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             wr_q;
    logic             dm_q;

    // Purpose: load, cut or count down the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            wr_q  <= 1'b0;
        end else if (start_i) begin
            cnt_q <= CNT_W'(BURST_LEN);
            wr_q  <= is_wr_i;
        end else if (stop_i && !wr_q) begin
            cnt_q <= '0;
        end else if (cnt_q != '0 && !freeze_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Purpose: sample the data mask on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dm_q <= 1'b1;
        else
            dm_q <= dm_i;
    end

    assign busy_o  = (cnt_q != '0);
    assign wr_en_o = busy_o && wr_q && !dm_q && run_i;
    assign rd_oe_o = busy_o && !wr_q && !dm_q && run_i;

    AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && rd_oe_o));  // R12
    AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(BURST_LEN));  // R12
    AST_STOP_ENDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i && !wr_q) |=> !busy_o);  // R8

endmodule

// File: rtl/ddrcmd_decoder.sv
// Module: top of the command decoder. It keeps the previous clock-enable
// level, renames the raw decode from the mode and the burst state, judges
// legality, holds the device mode and registers every output.
// Assumes: the pins are stable around the rising clock edge; reset is
// synchronous and held for at least one edge.
module ddrcmd_decoder
    import ddrcmd_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 8,
    parameter int AP_BIT    = 8,
    parameter int BURST_LEN = 4,
    localparam int NBANK    = 1 << BA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke_i,
    input  logic             cs_n_i,
    input  logic             ras_n_i,
    input  logic             cas_n_i,
    input  logic             we_n_i,
    input  logic [BA_W-1:0]  ba_i,
    input  logic [ROW_W-1:0] addr_i,
    input  logic             dm_i,
    output logic [4:0]       cmd_o,
    output logic             illegal_o,
    output logic [BA_W-1:0]  bank_o,
    output logic             ap_o,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o,
    output logic [NBANK-1:0] bank_active_o,
    output logic [1:0]       mode_o,
    output logic             burst_o,
    output logic             wr_en_o,
    output logic             rd_oe_o
);

    logic             cke_prev_q;
    cmd_e             raw;
    cmd_e             cmd_res;
    cmd_e             cmd_q;
    mode_e            mode_q;
    mode_e            mode_nxt;
    logic             legal;
    logic             ill_q;
    logic             normal;
    logic             freeze;
    logic             busy;
    logic             access;
    logic [NBANK-1:0] bank_active_w;
    logic [NBANK-1:0] bank_open_w;
    logic [BA_W-1:0]  bank_q;
    logic             ap_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;

    ddrcmd_pin_decode #(.BA_W(BA_W)) u_pins (
        .cke_prev_i (cke_prev_q),
        .cke_i      (cke_i),
        .cs_n_i     (cs_n_i),
        .ras_n_i    (ras_n_i),
        .cas_n_i    (cas_n_i),
        .we_n_i     (we_n_i),
        .ba_i       (ba_i),
        .qual_i     (addr_i[AP_BIT]),
        .raw_o      (raw)
    );

    assign normal = (mode_q == MODE_NORMAL);
    assign freeze = !cke_i || !normal;
    assign access = (cmd_res == CMD_WR) || (cmd_res == CMD_WRA) ||
                    (cmd_res == CMD_RD) || (cmd_res == CMD_RDA);

    // Purpose: rename power-down entry and exit from the burst and mode state.
    always_comb begin
        cmd_res = raw;
        if (raw == CMD_PD_IN && busy)
            cmd_res = CMD_SUSP_IN;
        else if (raw == CMD_PD_OUT) begin
            case (mode_q)
                MODE_SELF: cmd_res = CMD_SREF_OUT;
                MODE_SUSP: cmd_res = CMD_SUSP_OUT;
                default:   cmd_res = CMD_PD_OUT;
            endcase
        end
    end

    // Purpose: judge the resolved command against the bank and mode state.
    always_comb begin
        case (cmd_res)
            CMD_HOLD:                          legal = 1'b1;
            CMD_DESEL, CMD_NOP,
            CMD_PRE, CMD_PREA,
            CMD_PD_IN, CMD_SUSP_IN:            legal = normal;
            CMD_ACT:                           legal = normal && !bank_active_w[ba_i];
            CMD_WR, CMD_WRA, CMD_RD, CMD_RDA:  legal = normal && bank_open_w[ba_i];
            CMD_MRS, CMD_EMRS,
            CMD_AREF, CMD_SREF_IN:             legal = normal && (bank_active_w == '0);
            CMD_BST:                           legal = normal && (bank_active_w != '0);
            CMD_SREF_OUT, CMD_PD_OUT,
            CMD_SUSP_OUT:                      legal = !normal;
            default:                           legal = 1'b0;
        endcase
    end

    // Purpose: next device mode for an accepted command.
    always_comb begin
        case (cmd_res)
            CMD_SREF_IN:                            mode_nxt = MODE_SELF;
            CMD_PD_IN:                              mode_nxt = MODE_PDOWN;
            CMD_SUSP_IN:                            mode_nxt = MODE_SUSP;
            CMD_SREF_OUT, CMD_PD_OUT, CMD_SUSP_OUT: mode_nxt = MODE_NORMAL;
            default:                                mode_nxt = mode_q;
        endcase
    end

    ddrcmd_bank_track #(.BA_W(BA_W), .BURST_LEN(BURST_LEN)) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .freeze_i   (freeze),
        .act_i      (legal && cmd_res == CMD_ACT),
        .pre_i      (legal && cmd_res == CMD_PRE),
        .prea_i     (legal && cmd_res == CMD_PREA),
        .ap_start_i (legal && (cmd_res == CMD_WRA || cmd_res == CMD_RDA)),
        .bank_i     (ba_i),
        .active_o   (bank_active_w),
        .open_o     (bank_open_w)
    );

    ddrcmd_burst_ctl #(.BURST_LEN(BURST_LEN)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .freeze_i (freeze),
        .start_i  (legal && access),
        .is_wr_i  (cmd_res == CMD_WR || cmd_res == CMD_WRA),
        .stop_i   (legal && cmd_res == CMD_BST),
        .dm_i     (dm_i),
        .run_i    (normal),
        .busy_o   (busy),
        .wr_en_o  (wr_en_o),
        .rd_oe_o  (rd_oe_o)
    );

    // Purpose: remember the clock-enable level for the next decode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cke_prev_q <= 1'b1;
        else
            cke_prev_q <= cke_i;
    end

    // Purpose: register the reported command and its verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= CMD_NOP;
            ill_q  <= 1'b0;
            bank_q <= '0;
            ap_q   <= 1'b0;
        end else begin
            cmd_q  <= cmd_res;
            ill_q  <= !legal;
            bank_q <= ba_i;
            ap_q   <= addr_i[AP_BIT];
        end
    end

    // Purpose: capture row and column addresses of accepted commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else begin
            if (legal && cmd_res == CMD_ACT)
                row_q <= addr_i;
            if (legal && access)
                col_q <= addr_i[COL_W-1:0];
        end
    end

    // Purpose: hold the device mode, changed only by accepted commands.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_NORMAL;
        else if (legal)
            mode_q <= mode_nxt;
    end

    assign cmd_o         = cmd_q;
    assign illegal_o     = ill_q;
    assign bank_o        = bank_q;
    assign ap_o          = ap_q;
    assign row_o         = row_q;
    assign col_o         = col_q;
    assign bank_active_o = bank_active_w;
    assign mode_o        = mode_q;
    assign burst_o       = busy;

    AST_ILLEGAL_HOLDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        ill_q |-> (mode_q == $past(mode_q)));  // R13
    AST_ACT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_ACT && !ill_q) |-> ((($past(bank_active_w) >> bank_q) & NBANK'(1)) == '0));  // R3
    AST_PREA_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_PREA && !ill_q) |-> (bank_active_w == '0));  // R4
    AST_MODE_NEEDS_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_NORMAL && $past(mode_q) == MODE_NORMAL) |-> !$past(cke_i));  // R10
    AST_SUSPEND_OUTPUTS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SUSP) |-> (!wr_en_o && !rd_oe_o));  // R11

endmodule

// File: tb/ddrcmd_decoder_bench.sv
module ddrcmd_decoder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BL         = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;
    logic        dm = 1'b1;
    logic [4:0]  cmd;
    logic        ill, ap, burst, wr_en, rd_oe;
    logic [1:0]  bank, mode;
    logic [11:0] row;
    logic [7:0]  col;
    logic [3:0]  act;
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ddrcmd_decoder #(.BURST_LEN(BL)) u_ddrcmd_decoder (
        .clk(clk), .rst_n(rst_n), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
        .cas_n_i(cas_n), .we_n_i(we_n), .ba_i(ba), .addr_i(addr), .dm_i(dm),
        .cmd_o(cmd), .illegal_o(ill), .bank_o(bank), .ap_o(ap), .row_o(row),
        .col_o(col), .bank_active_o(act), .mode_o(mode), .burst_o(burst),
        .wr_en_o(wr_en), .rd_oe_o(rd_oe)
    );

    // Row layout: cke cs_n ras cas we | ba | a8 | cmd | illegal | banks | mode
    localparam logic [19:0] VEC [28] = '{
        20'b1_0_111_00_0_00001_0_0000_00, // R2 NOP
        20'b1_1_000_00_0_00000_0_0000_00, // R2 DESEL ignores strobes
        20'b1_0_101_00_0_00111_1_0000_00, // R5 R13 read to idle bank
        20'b1_0_011_10_0_00010_0_0100_00, // R3 ACT bank 2
        20'b1_0_011_10_0_00010_1_0100_00, // R3 R13 ACT to active bank
        20'b1_0_000_00_0_01001_1_0100_00, // R7 MRS with a bank open
        20'b1_0_100_10_0_00101_0_0100_00, // R5 WR bank 2
        20'b1_0_001_00_0_01100_1_0100_00, // R9 AREF with a bank open
        20'b1_0_011_00_0_00010_0_0101_00, // R3 ACT bank 0
        20'b1_0_010_10_0_00011_0_0001_00, // R4 PRE bank 2
        20'b1_0_010_10_1_00100_0_0000_00, // R4 PREA ignores bank bits
        20'b1_0_000_00_0_01001_0_0000_00, // R7 MRS
        20'b1_0_000_01_0_01010_0_0000_00, // R7 EMRS
        20'b1_0_000_10_0_10100_1_0000_00, // R7 undefined bank code
        20'b1_0_110_00_0_01011_1_0000_00, // R8 BST with all idle
        20'b1_0_001_00_0_01100_0_0000_00, // R9 AREF
        20'b0_0_001_00_0_01101_0_0000_01, // R9 SREF_IN
        20'b0_0_111_00_0_10011_0_0000_01, // R10 HOLD
        20'b0_0_011_00_0_10011_0_0000_01, // R10 HOLD ignores ACT pins
        20'b1_1_000_00_0_01110_0_0000_00, // R9 SREF_OUT
        20'b0_0_111_00_0_01111_0_0000_10, // R10 PD_IN from idle
        20'b1_0_111_00_0_10000_0_0000_00, // R10 PD_OUT
        20'b1_0_011_01_0_00010_0_0010_00, // R3 ACT bank 1
        20'b0_1_000_00_0_01111_0_0010_10, // R10 PD_IN from active
        20'b1_1_000_00_0_10000_0_0010_00, // R10 PD_OUT
        20'b0_0_011_00_0_10100_1_0010_00, // R13 cke fall with ACT pins
        20'b1_0_111_00_0_10000_1_0010_00, // R13 exit while normal
        20'b1_0_010_00_1_00100_0_0000_00  // R4 PREA
    };

    task automatic chk(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic issue(input logic k, input logic cs, input logic [2:0] rcw,
                         input logic [1:0] b, input logic [11:0] a, input logic m);
        cke = k; cs_n = cs; {ras_n, cas_n, we_n} = rcw; ba = b; addr = a; dm = m;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual %0d expected 0", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 reset cmd", cmd, 1);
        chk("R1 reset illegal", ill, 0);
        chk("R1 reset banks", act, 0);
        chk("R1 reset mode", mode, 0);
        chk("R1 reset burst", burst, 0);
        chk("R1 reset wr_en", wr_en, 0);

        foreach (VEC[i]) begin
            logic [19:0] v;
            v = VEC[i];
            issue(v[19], v[18], v[17:15], v[14:13], 12'(v[12]) << 8, 1'b1);
            chk($sformatf("R1 row %0d cmd", i), cmd, v[11:7]);
            chk($sformatf("R13 row %0d illegal", i), ill, v[6]);
            chk($sformatf("R13 row %0d banks", i), act, v[5:2]);
            chk($sformatf("R1 row %0d mode", i), mode, v[1:0]);
        end

        // R3 row capture, R5 column and qualifier, R6 auto-precharge timing
        issue(1, 0, 3'b011, 2'd3, 12'hA5C, 1);
        chk("R3 row_o", row, 12'hA5C);
        chk("R3 bank_o", bank, 3);
        issue(1, 0, 3'b101, 2'd3, 12'h1C3, 0);
        chk("R5 RDA cmd", cmd, 8);
        chk("R5 col_o", col, 8'hC3);
        chk("R5 ap_o", ap, 1);
        chk("R12 read burst", burst, 1);
        chk("R12 rd_oe unmasked", rd_oe, 1);
        issue(1, 0, 3'b101, 2'd3, 12'h012, 1);
        chk("R6 access during pending precharge", ill, 1);
        chk("R6 bank still active 1", act, 4'b1000);
        chk("R12 rd_oe masked", rd_oe, 0);
        chk("R5 col_o kept on illegal", col, 8'hC3);
        issue(1, 0, 3'b111, 2'd0, 12'h000, 0);
        chk("R6 bank still active 2", act, 4'b1000);
        chk("R12 rd_oe again", rd_oe, 1);
        issue(1, 0, 3'b111, 2'd0, 12'h000, 1);
        chk("R6 bank idle after burst", act, 0);
        chk("R12 burst over", burst, 0);

        // R8 burst stop cuts a read
        issue(1, 0, 3'b011, 2'd0, 12'h003, 1);
        issue(1, 0, 3'b101, 2'd0, 12'h004, 0);
        chk("R8 read burst running", burst, 1);
        issue(1, 0, 3'b110, 2'd0, 12'h000, 1);
        chk("R8 BST cmd", cmd, 11);
        chk("R8 BST legal", ill, 0);
        chk("R8 burst cut", burst, 0);
        chk("R8 bank stays active", act, 4'b0001);
        issue(1, 0, 3'b010, 2'd0, 12'h100, 1);

        // R11 clock suspend freezes and resumes a write burst
        issue(1, 0, 3'b011, 2'd1, 12'h005, 1);
        issue(1, 0, 3'b100, 2'd1, 12'h006, 0);
        chk("R12 wr_en in write burst", wr_en, 1);
        issue(0, 0, 3'b111, 2'd0, 12'h000, 0);
        chk("R11 SUSP_IN cmd", cmd, 17);
        chk("R11 suspend mode", mode, 3);
        chk("R11 wr_en off in suspend", wr_en, 0);
        chk("R11 burst held", burst, 1);
        issue(0, 0, 3'b111, 2'd0, 12'h000, 0);
        chk("R10 HOLD in suspend", cmd, 19);
        issue(1, 1, 3'b000, 2'd0, 12'h000, 0);
        chk("R11 SUSP_OUT cmd", cmd, 18);
        chk("R11 mode normal", mode, 0);
        chk("R11 burst resumes", burst, 1);
        chk("R12 wr_en after resume", wr_en, 1);
        issue(1, 0, 3'b111, 2'd0, 12'h000, 1);
        chk("R12 wr_en masked", wr_en, 0);
        issue(1, 0, 3'b111, 2'd0, 12'h000, 0);
        chk("R11 burst last cycle", burst, 1);
        issue(1, 0, 3'b111, 2'd0, 12'h000, 0);
        chk("R11 burst ends", burst, 0);
        chk("R12 wr_en ends", wr_en, 0);

        finish_run();
    end

endmodule